// File: doc/BRIEF.md
# MDIO Management Master

This block is the master side of the two-wire PHY management bus. Software first loads an address register that packs a 5-bit PHY address and a 5-bit register address. Then it starts one of two frames. A write frame starts as a side effect of strobing a 16-bit value into the write-data register. A read frame starts on a rising edge of a software-held read command bit. While a frame is in progress, `busy_o` stays high. When a read frame ends, the 16 bits returned by the PHY appear on `rd_data_o`.

The management clock is derived from the host clock. A 2-bit selector picks one of four divide ratios, and the largest ratio is 28. Each frame has 64 MDC periods, sent most significant bit first:

- a preamble of ones;
- the start pattern;
- the opcode;
- the two address fields;
- the turnaround;
- sixteen data bits.

The master drives MDIO through a separate output-enable. It changes the driven value only on the falling MDC edge, and it samples read data on the rising MDC edge. It releases the line during idle, and it also releases it from the first turnaround bit of a read to the end of that read.

Top module: `mdio_master`

## Requirements
- R1: After reset, `busy_o`, `mdc_o` and `mdio_oe_o` are 0, and `rd_data_o` is 0.
- R2: A `wr_we_i` strobe while idle sends a write frame. The frame is 32 ones, then 01, then opcode 01, then `addr_i[9:5]` (PHY), then `addr_i[4:0]` (register), then 10, then `wr_data_i`, each field MSB first. All 64 bits are driven (`mdio_oe_o`=1).
- R3: A rising edge of `read_cmd_i` while idle sends a read frame with the same preamble, start and address fields and opcode 10. `mdio_oe_o` is 0 for bit positions 46 to 63 of the frame (turnaround and data).
- R4: In a read frame, the values of `mdio_i` at the rising MDC edges of frame bits 48 to 63 form the read word, MSB first. It appears on `rd_data_o` when `busy_o` falls. `rd_data_o` does not change at any other time, including across write frames.
- R5: `busy_o` is high for exactly 64 × D host clock cycles per frame, where D is the divide ratio in effect at the start of the frame.
- R6: `div_sel_i` encoding: 0 selects D=4, 1 selects D=8, 2 selects D=16, 3 selects D=28. The selector is latched at frame start. MDC is high for D/2 host cycles of each period.
- R7: `mdio_o` and `mdio_oe_o` never change while MDC stays high. Changes happen only together with a falling MDC edge or at frame start.
- R8: While idle, `mdc_o` is 0 and `mdio_oe_o` is 0.
- R9: A `wr_we_i` strobe or a rising edge of `read_cmd_i` that arrives while busy is ignored. No extra frame follows, even if `read_cmd_i` stays high.
- R10: Holding `read_cmd_i` high after a read does not start another read. A new read needs the bit to be cleared and set again.
- R11: If `wr_we_i` and a rising edge of `read_cmd_i` occur in the same idle cycle, only the write frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_we_i | input | 1 | Load the address register |
| addr_i | input | 10 | PHY address [9:5], register address [4:0] |
| wr_we_i | input | 1 | Write-data strobe, starts a write frame |
| wr_data_i | input | 16 | Data for a write frame |
| read_cmd_i | input | 1 | Read command bit; its rising edge starts a read frame |
| div_sel_i | input | 2 | MDC divide ratio select |
| mdio_i | input | 1 | MDIO line as seen from the pad |
| busy_o | output | 1 | Frame in progress |
| rd_data_o | output | 16 | Last word read from a PHY |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe_o | output | 1 | MDIO drive enable |

## Verification
The bench sends write and read frames to all 32 PHY addresses at the fastest ratio, and it exercises every divide ratio. It rebuilds each captured frame arithmetically and checks it bit by bit. This catches a shifted field, a wrong opcode, and an early or late line release: a master that drove during the turnaround would show up in the enable pattern, and one that sampled one bit off would return a shifted word. The bench also issues commands while busy, holds the read bit high, and collides a write with a read edge. A design with weak edge detection or a missing busy guard would then send a second frame, and the bench would count more than 64 MDC rises. It also checks that `rd_data_o` survives a write frame, and it counts the MDC high time and the busy time for each ratio.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W   = 5;
  localparam int REG_W   = 5;
  localparam int DATA_W  = 16;
  localparam int PRE_LEN = 32;
  localparam int SEL_W   = 2;
  localparam int CNT_W   = 5;
  localparam int HDR_W      = 4 + PHY_W + REG_W;
  localparam int POST_W     = HDR_W + 2 + DATA_W;
  localparam int FRAME_BITS = PRE_LEN + POST_W;

  typedef enum logic [1:0] {
    OP_WR = 2'b01,
    OP_RD = 2'b10
  } mdio_op_e;

  function automatic logic [CNT_W-1:0] div_of(logic [SEL_W-1:0] sel);
    case (sel)
      2'd0:    return CNT_W'(4);
      2'd1:    return CNT_W'(8);
      2'd2:    return CNT_W'(16);
      default: return CNT_W'(28);
    endcase
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half;

  assign half   = div_i >> 1;
  assign rise_o = run_i && (cnt_q == half - CNT_W'(1));
  assign fall_o = run_i && (cnt_q == div_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else begin
      cnt_q <= fall_o ? '0 : cnt_q + CNT_W'(1);
      if (rise_o)      mdc_o <= 1'b1;
      else if (fall_o) mdc_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_serializer.sv
module mdio_serializer
  import mdio_pkg::*;
#(
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [PHY_W-1:0]  phy_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int L_HDR   = 4 + PHY_W + REG_W;
  localparam int L_POST  = L_HDR + 2 + DATA_W;
  localparam int L_FRAME = PRE_LEN + L_POST;
  localparam int IDX_W   = $clog2(L_FRAME);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(L_FRAME - 1);
  localparam logic [IDX_W-1:0] PRE_END  = IDX_W'(PRE_LEN);
  localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(PRE_LEN + L_HDR);
  localparam logic [IDX_W-1:0] CAP_IDX  = IDX_W'(PRE_LEN + L_HDR + 2);

  logic              busy_q, rd_q;
  logic [IDX_W-1:0]  idx_q;
  logic [L_POST-1:0] word_q;
  logic [DATA_W-1:0] cap_q, rd_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      rd_q      <= 1'b0;
      idx_q     <= '0;
      word_q    <= '0;
      cap_q     <= '0;
      rd_data_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      rd_q   <= rd_i;
      idx_q  <= '0;
      word_q <= {2'b01, (rd_i ? OP_RD : OP_WR), phy_i, reg_i, 2'b10,
                 (rd_i ? {DATA_W{1'b0}} : data_i)};
    end else if (busy_q) begin
      if (rise_i && rd_q && idx_q >= CAP_IDX) cap_q <= {cap_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        idx_q <= idx_q + IDX_W'(1);
        if (idx_q >= PRE_END) word_q <= word_q << 1;
        if (idx_q == LAST_IDX) begin
          busy_q <= 1'b0;
          if (rd_q) rd_data_q <= cap_q;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign rd_data_o = rd_data_q;
  // idle line reads as ones; drive enable carries the real state
  assign mdio_o    = !busy_q || (idx_q < PRE_END) || word_q[L_POST-1];
  assign mdio_oe_o = busy_q && !(rd_q && idx_q >= REL_IDX);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int P_PHY_W   = PHY_W,
  parameter int P_REG_W   = REG_W,
  parameter int P_DATA_W  = DATA_W,
  parameter int P_PRE_LEN = PRE_LEN
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       addr_we_i,
  input  logic [P_PHY_W+P_REG_W-1:0] addr_i,
  input  logic                       wr_we_i,
  input  logic [P_DATA_W-1:0]        wr_data_i,
  input  logic                       read_cmd_i,
  input  logic [SEL_W-1:0]           div_sel_i,
  input  logic                       mdio_i,
  output logic                       busy_o,
  output logic [P_DATA_W-1:0]        rd_data_o,
  output logic                       mdc_o,
  output logic                       mdio_o,
  output logic                       mdio_oe_o
);
  localparam int ADDR_W = P_PHY_W + P_REG_W;

  logic [ADDR_W-1:0] addr_q;
  logic              rd_prev_q;
  logic [CNT_W-1:0]  div_q;
  logic              start_wr, start_rd, start, rise, fall;

  // write strobe wins over a coincident read edge
  assign start_wr = wr_we_i && !busy_o;
  assign start_rd = read_cmd_i && !rd_prev_q && !busy_o && !wr_we_i;
  assign start    = start_wr || start_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      rd_prev_q <= 1'b0;
      div_q     <= CNT_W'(4);
    end else begin
      rd_prev_q <= read_cmd_i;
      if (addr_we_i) addr_q <= addr_i;
      if (start)     div_q  <= div_of(div_sel_i);
    end
  end

  mdio_clkgen #(.CNT_W(CNT_W)) u_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .div_i  (div_q),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_serializer #(
    .PHY_W  (P_PHY_W),
    .REG_W  (P_REG_W),
    .DATA_W (P_DATA_W),
    .PRE_LEN(P_PRE_LEN)
  ) u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .rd_i     (start_rd),
    .phy_i    (addr_q[ADDR_W-1:P_REG_W]),
    .reg_i    (addr_q[P_REG_W-1:0]),
    .data_i   (wr_data_i),
    .rise_i   (rise),
    .fall_i   (fall),
    .mdio_i   (mdio_i),
    .busy_o   (busy_o),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o),
    .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              mdc_o,
  input logic              mdio_o,
  input logic              mdio_oe_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [SEL_W-1:0]  div_sel_i
);
  logic [SEL_W-1:0] sel_q;
  logic             busy_q;
  logic [15:0]      cnt_q, exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      exp_q  <= '0;
    end else begin
      sel_q  <= div_sel_i;
      busy_q <= busy_o;
      if (busy_o && !busy_q) begin
        cnt_q <= 16'd1;
        exp_q <= 16'(FRAME_BITS) * 16'(div_of(sel_q));
      end else if (busy_o) begin
        cnt_q <= cnt_q + 16'd1;
      end
    end
  end

  // R8
  p_idle_released_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mdio_oe_o && !mdc_o));
  // R7
  p_stable_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));
  // R5
  p_busy_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (cnt_q == exp_q));
  // R4
  p_rd_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> $stable(rd_data_o));
  // R6
  p_mdc_in_frame_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> busy_o);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_o   (busy_o),
  .mdc_o    (mdc_o),
  .mdio_o   (mdio_o),
  .mdio_oe_o(mdio_oe_o),
  .rd_data_o(rd_data_o),
  .div_sel_i(div_sel_i)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
  import mdio_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        addr_we, wr_we, read_cmd, mdio_in;
  logic [9:0]  addr;
  logic [15:0] wr_data;
  logic [1:0]  div_sel;
  logic        busy, mdc, mdio_out, mdio_oe;
  logic [15:0] rd_data;

  mdio_master uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_we_i(addr_we), .addr_i(addr),
    .wr_we_i(wr_we), .wr_data_i(wr_data), .read_cmd_i(read_cmd),
    .div_sel_i(div_sel), .mdio_i(mdio_in), .busy_o(busy),
    .rd_data_o(rd_data), .mdc_o(mdc), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int rises = 0, busy_cnt = 0, hi_cnt = 0, viol = 0;
  logic [63:0] cap_v, cap_oe;
  logic [15:0] phy_val = 16'h0;
  logic prev_mdc = 1'b0, prev_mdio = 1'b1;

  always @(posedge mdc) begin
    if (rises < 64) begin
      cap_v[63-rises]  = mdio_out;
      cap_oe[63-rises] = mdio_oe;
    end
    rises++;
  end

  // PHY model: turnaround low bit at 47, data on 48..63
  always @(negedge mdc) begin
    if (rises == 47) mdio_in = 1'b0;
    else if (rises >= 48 && rises < 64) mdio_in = phy_val[63-rises];
    else mdio_in = 1'b1;
  end

  always @(posedge clk) begin
    if (busy) busy_cnt++;
    if (mdc) hi_cnt++;
    if (mdc && prev_mdc && mdio_out !== prev_mdio) viol++;
    prev_mdc  = mdc;
    prev_mdio = mdio_out;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int div_val(input logic [1:0] s);
    return (s == 2'd3) ? 28 : (4 << s);
  endfunction

  task automatic clear_mon();
    rises = 0; busy_cnt = 0; hi_cnt = 0; cap_v = '0; cap_oe = '0;
  endtask

  task automatic set_addr(input logic [4:0] p, input logic [4:0] r);
    @(negedge clk); addr_we = 1'b1; addr = {p, r};
    @(negedge clk); addr_we = 1'b0;
  endtask

  task automatic wait_idle();
    int g = 0;
    @(negedge clk);
    while (busy && g < 4000) begin @(negedge clk); g++; end
    if (g >= 4000) check(1'b0, "watchdog", 64'(g), 64'd0);
  endtask

  task automatic check_frame(input bit rd, input logic [4:0] p, input logic [4:0] r,
                             input logic [15:0] d, input logic [1:0] s, input string req);
    logic [63:0] ev, mask, eoe;
    int dv = div_val(s);
    ev   = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, 2'b10, d};
    mask = rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
    eoe  = mask;
    check(((cap_v ^ ev) & mask) == 64'd0, {req, " frame bits"}, cap_v & mask, ev & mask);
    check(cap_oe == eoe, {req, " drive enable R3"}, cap_oe, eoe);
    check(busy_cnt == 64*dv, "R5 busy length", 64'(busy_cnt), 64'(64*dv));
    check(hi_cnt == 32*dv, "R6 mdc high time", 64'(hi_cnt), 64'(32*dv));
    check(rises == 64 && !mdc && !mdio_oe, "R8 idle after frame", 64'(rises), 64'd64);
  endtask

  task automatic do_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d, input logic [1:0] s);
    div_sel = s;
    set_addr(p, r);
    clear_mon();
    @(negedge clk); wr_we = 1'b1; wr_data = d;
    @(negedge clk); wr_we = 1'b0;
    wait_idle();
    check_frame(1'b0, p, r, d, s, "R2");
  endtask

  task automatic do_read(input logic [4:0] p, input logic [4:0] r, input logic [15:0] v,
                         input logic [1:0] s, input bit hold);
    div_sel = s;
    phy_val = v;
    set_addr(p, r);
    clear_mon();
    @(negedge clk); read_cmd = 1'b1;
    @(negedge clk); if (!hold) read_cmd = 1'b0;
    wait_idle();
    check_frame(1'b1, p, r, 16'h0, s, "R3");
    check(rd_data == v, "R4 read word", 64'(rd_data), 64'(v));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'd0, 64'd1);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr_we = 0; wr_we = 0; read_cmd = 0; mdio_in = 1'b1;
    addr = '0; wr_data = '0; div_sel = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !mdc && !mdio_oe && rd_data == 16'h0, "R1 reset state",
          {60'd0, busy, mdc, mdio_oe, |rd_data}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mdc && !mdio_oe, "R8 idle after reset", {61'd0, busy, mdc, mdio_oe}, 64'd0);

    // R2 sweep over all PHY addresses at the fastest ratio
    for (int i = 0; i < 32; i++)
      do_write(5'(i), 5'(~i), 16'((i * 2053) ^ 16'hA5C3), 2'd0);
    // R3/R4 read sweep
    for (int i = 0; i < 32; i++)
      do_read(5'(i), 5'(i * 7), 16'((i * 40503) ^ 16'h5A17), 2'd0, 1'b0);

    // R6 each divide ratio
    for (int s = 1; s < 4; s++) begin
      do_write(5'(s * 9), 5'(s + 3), 16'(16'h1234 * s), 2'(s));
      do_read(5'(s * 5), 5'(s * 11), 16'(16'hC0DE ^ (s * 16'h0F0F)), 2'(s), 1'b0);
    end

    // R4 write frame leaves last read word intact
    do_read(5'd3, 5'd4, 16'hBEEF, 2'd0, 1'b0);
    do_write(5'd3, 5'd4, 16'h0001, 2'd0);
    check(rd_data == 16'hBEEF, "R4 kept across write", 64'(rd_data), 64'hBEEF);

    // R9 commands while busy
    div_sel = 2'd0;
    set_addr(5'd5, 5'd9);
    clear_mon();
    @(negedge clk); wr_we = 1'b1; wr_data = 16'h3C96;
    @(negedge clk); wr_we = 1'b0;
    repeat (100) @(negedge clk);
    wr_we = 1'b1; wr_data = 16'hFFFF; read_cmd = 1'b1;
    @(negedge clk); wr_we = 1'b0;
    wait_idle();
    check_frame(1'b0, 5'd5, 5'd9, 16'h3C96, 2'd0, "R9");
    repeat (300) @(negedge clk);
    check(!busy && rises == 64, "R9 no extra frame", 64'(rises), 64'd64);
    read_cmd = 1'b0;
    @(negedge clk);

    // R10 held read bit
    do_read(5'd17, 5'd2, 16'h8001, 2'd0, 1'b1);
    repeat (300) @(negedge clk);
    check(!busy && rises == 64, "R10 held bit no restart", 64'(rises), 64'd64);
    read_cmd = 1'b0;
    @(negedge clk);
    do_read(5'd17, 5'd2, 16'h7FFE, 2'd0, 1'b0);

    // R11 write beats coincident read edge
    set_addr(5'd30, 5'd1);
    clear_mon();
    @(negedge clk); wr_we = 1'b1; wr_data = 16'h0F0F; read_cmd = 1'b1;
    @(negedge clk); wr_we = 1'b0; read_cmd = 1'b0;
    wait_idle();
    check_frame(1'b0, 5'd30, 5'd1, 16'h0F0F, 2'd0, "R11");
    repeat (300) @(negedge clk);
    check(!busy && rises == 64, "R11 single frame", 64'(rises), 64'd64);

    // R7 line never moved while MDC high
    check(viol == 0, "R7 change while mdc high", 64'(viol), 64'd0);

    summary();
    $finish;
  end
endmodule